// File: doc/BRIEF.md
# Dual-Controller Compute Kernel with Hidden Signature Mode

This block is a short fixed-schedule arithmetic kernel. One datapath (four 32-bit working registers, one adder/subtractor/logic unit, one internal storage word and one accumulator) is shared by two controllers. In normal operation a functional controller walks an eight-step schedule over two operands and returns a computed value. When the `trigger` pin is high at the moment a job is accepted, the functional controller stays parked and a second controller drives the same units through a reduced version of the schedule. It then returns a signature word that proves which key the block was built with.

The reduction is set by the `OP_KEY` parameter, one bit per schedule step. On a keyable arithmetic step a set bit runs the operation and a clear bit bypasses it, forwarding one fixed operand. The step that fills a loop-style control role always runs. In signature mode the storage write is suppressed and each value that would have been stored is added into an accumulator instead. The storage read returns the constant `LOAD_CONST`. The accumulated sum is the signature.

The input side is a valid/ready pair: a job is accepted on a rising clock edge where `start` and `in_ready` are both high. Holding `start` high while `in_ready` is low has no effect. Because the block never stalls its output, the output side has no back-pressure: `done` is a one-cycle valid strobe, and `result` holds its value until the next `done`.

Top module: `wm_kernel`

## Requirements
- R1: After reset `in_ready` is 1, `done` is 0 and `result` is 0; `in_ready` drops in the cycle after an acceptance and stays low until the cycle in which `done` is high.
- R2: `done` is high for exactly one cycle, the ninth cycle after the acceptance edge (eight step cycles, then one), and `result` stays unchanged until the next `done`.
- R3: With `trigger` low at acceptance, `result` = (((a^b) - (a+b)) & (a+b)) + (a+b), modulo 2^32, where a and b are the operands captured at acceptance.
- R4: `trigger` is sampled only at acceptance. While it is high, the functional controller never leaves idle, and a change of `trigger` during a job does not change that job's mode. A high `trigger` with no `start` starts nothing.
- R5: In signature mode, `OP_KEY` bits 0, 1, 3 and 5 control the keyable steps. A 1 executes the step, and a 0 bypasses it. The steps are: step 0 r0=a+b, bypass a; step 1 r1=a^b, bypass b; step 3 r2=r1-r0, bypass r0; step 5 r2=r2&r3, bypass r2.
- R6: Step 6 (r0=r2+r3) always executes. `OP_KEY` bits 2, 4, 6 and 7 have no effect on the signature.
- R7: In signature mode, the storage read at step 4 loads `LOAD_CONST` into r3. In functional mode it loads the word written at step 2.
- R8: In signature mode, the stores at steps 2 and 7 (both of r0) do not write storage; their values are summed modulo 2^32, and that sum is `result`.
- R9: A signature job leaves a following functional job's result exactly as R3 gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Job valid |
| in_ready | output | 1 | Kernel idle and able to accept a job |
| trigger | input | 1 | Selects signature mode when sampled at acceptance |
| input_a | input | DW | First operand |
| input_b | input | DW | Second operand |
| result | output | DW | Computed value or signature, held until the next done |
| done | output | 1 | One-cycle result strobe |

## Verification
Operand pairs are chosen to expose specific faults. An all-zero pair checks reset-like behaviour. Carry-heavy pairs (all ones plus one, two top-bit-only words) catch wrong add/subtract wrapping. Alternating bit patterns separate XOR from AND and from swapped operands. Two instances built with different keys see the same operands, so a bypass that picks the wrong operand or obeys a key bit it should ignore gives a signature that differs from the model. Trigger changes in the middle of a job, start pulses while busy, and a functional job right after a signature job check that mode is latched once and that the shared datapath carries no state between modes.

// File: rtl/wm_pkg.sv
package wm_pkg;

  localparam int STEPS = 8;
  localparam int SW    = $clog2(STEPS);

  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_XOR, OP_AND} alu_op_e;
  typedef enum logic [1:0] {K_ALU, K_CTRL, K_LOAD, K_STORE} kind_e;
  typedef enum logic [2:0] {S_R0, S_R1, S_R2, S_R3, S_A, S_B} src_e;

  typedef struct packed {
    kind_e   kind;
    alu_op_e op;
    logic [1:0] dst;
    src_e    sa;
    src_e    sb;
    logic    pick_b;   // bypass forwards sb when set, sa otherwise
  } sched_t;

  function automatic sched_t sched_at(input logic [SW-1:0] s);
    sched_t e;
    e = '{kind: K_CTRL, op: OP_ADD, dst: 2'd0, sa: S_R0, sb: S_R0, pick_b: 1'b0};
    case (s)
      3'd0: e = '{kind: K_ALU,   op: OP_ADD, dst: 2'd0, sa: S_A,  sb: S_B,  pick_b: 1'b0};
      3'd1: e = '{kind: K_ALU,   op: OP_XOR, dst: 2'd1, sa: S_A,  sb: S_B,  pick_b: 1'b1};
      3'd2: e = '{kind: K_STORE, op: OP_ADD, dst: 2'd0, sa: S_R0, sb: S_R0, pick_b: 1'b0};
      3'd3: e = '{kind: K_ALU,   op: OP_SUB, dst: 2'd2, sa: S_R1, sb: S_R0, pick_b: 1'b1};
      3'd4: e = '{kind: K_LOAD,  op: OP_ADD, dst: 2'd3, sa: S_R0, sb: S_R0, pick_b: 1'b0};
      3'd5: e = '{kind: K_ALU,   op: OP_AND, dst: 2'd2, sa: S_R2, sb: S_R3, pick_b: 1'b0};
      3'd6: e = '{kind: K_CTRL,  op: OP_ADD, dst: 2'd0, sa: S_R2, sb: S_R3, pick_b: 1'b0};
      default: e = '{kind: K_STORE, op: OP_ADD, dst: 2'd0, sa: S_R0, sb: S_R0, pick_b: 1'b0};
    endcase
    return e;
  endfunction

endpackage

// File: rtl/wm_func_ctrl.sv
module wm_func_ctrl
  import wm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          hold,
  output logic          busy,
  output logic [SW-1:0] step,
  output logic          last
);

  assign last = busy && (step == SW'(STEPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (go) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      step <= step + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  // R4: an idle functional controller stays parked while hold is high and no go arrives
  p_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hold && !go) |=> !busy);

endmodule

// File: rtl/wm_pay_ctrl.sv
module wm_pay_ctrl
  import wm_pkg::*;
#(
  parameter logic [STEPS-1:0] OP_KEY = 8'h23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          busy,
  output logic [SW-1:0] step,
  output logic          last,
  output logic          keep,
  output logic          load_const,
  output logic          store_we,
  output logic          sig_add
);

  sched_t sc;

  assign sc         = sched_at(step);
  assign last       = busy && (step == SW'(STEPS - 1));
  assign keep       = (sc.kind == K_CTRL) || ((sc.kind == K_ALU) && OP_KEY[step]);
  assign load_const = 1'b1;
  assign store_we   = 1'b0;
  assign sig_add    = (sc.kind == K_STORE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (go) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      step <= step + 1'b1;
      if (last) busy <= 1'b0;
    end
  end

  // R6: the control step is never bypassed whatever the key holds
  p_ctrl_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == SW'(6)) |-> keep);

endmodule

// File: rtl/wm_datapath.sv
module wm_datapath
  import wm_pkg::*;
#(
  parameter int            DW         = 32,
  parameter logic [DW-1:0] LOAD_CONST = 32'h5A5A_C3C3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          step_en,
  input  logic [SW-1:0] step,
  input  logic          keep,
  input  logic          load_const,
  input  logic          store_we,
  input  logic          sig_add,
  input  logic          finish,
  input  logic          sel_sig,
  output logic [DW-1:0] result
);

  logic [DW-1:0] rf [4];
  logic [DW-1:0] a_q, b_q, mem_q, sig_q;
  logic [DW-1:0] va, vb, alu_y, byp_y, wr_y;
  sched_t sc;

  assign sc = sched_at(step);

  function automatic logic [DW-1:0] pick(input src_e s, input logic [DW-1:0] r0,
      input logic [DW-1:0] r1, input logic [DW-1:0] r2, input logic [DW-1:0] r3,
      input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (s)
      S_R0:    return r0;
      S_R1:    return r1;
      S_R2:    return r2;
      S_R3:    return r3;
      S_A:     return a;
      default: return b;
    endcase
  endfunction

  always_comb begin
    va = pick(sc.sa, rf[0], rf[1], rf[2], rf[3], a_q, b_q);
    vb = pick(sc.sb, rf[0], rf[1], rf[2], rf[3], a_q, b_q);
    case (sc.op)
      OP_ADD:  alu_y = va + vb;
      OP_SUB:  alu_y = va - vb;
      OP_XOR:  alu_y = va ^ vb;
      default: alu_y = va & vb;
    endcase
    byp_y = sc.pick_b ? vb : va;
    if (sc.kind == K_LOAD) wr_y = load_const ? LOAD_CONST : mem_q;
    else                   wr_y = keep ? alu_y : byp_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) rf[i] <= '0;
      a_q    <= '0;
      b_q    <= '0;
      mem_q  <= '0;
      sig_q  <= '0;
      result <= '0;
    end else begin
      if (accept) begin
        a_q   <= a_in;
        b_q   <= b_in;
        sig_q <= '0;
      end
      if (step_en) begin
        if (sc.kind == K_STORE) begin
          if (store_we) mem_q <= va;
          if (sig_add)  sig_q <= sig_q + va;
        end else begin
          rf[sc.dst] <= wr_y;
        end
      end
      if (finish) result <= sel_sig ? (sig_q + va) : rf[0];
    end
  end

  // R7: a read replaced by the constant lands in r3
  p_const_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sc.kind == K_LOAD && load_const) |=> (rf[3] == LOAD_CONST));

  // R8: a suppressed store leaves the storage word untouched
  p_store_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && sc.kind == K_STORE && !store_we) |=> $stable(mem_q));

  // R2: result only moves when a job finishes
  p_result_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result));

endmodule

// File: rtl/wm_kernel.sv
module wm_kernel
  import wm_pkg::*;
#(
  parameter int               DW         = 32,
  parameter logic [STEPS-1:0] OP_KEY     = 8'h23,
  parameter logic [DW-1:0]    LOAD_CONST = 32'h5A5A_C3C3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          in_ready,
  input  logic          trigger,
  input  logic [DW-1:0] input_a,
  input  logic [DW-1:0] input_b,
  output logic [DW-1:0] result,
  output logic          done
);

  logic          accept, go_f, go_p;
  logic          fc_busy, fc_last, pc_busy, pc_last;
  logic [SW-1:0] fc_step, pc_step, step;
  logic          pc_keep, pc_lc, pc_we, pc_sig;
  logic          keep, load_const, store_we, sig_add;
  logic          step_en, finish;
  sched_t        fsc;

  assign in_ready = !(fc_busy || pc_busy);
  assign accept   = start && in_ready;
  assign go_f     = accept && !trigger;
  assign go_p     = accept && trigger;

  wm_func_ctrl u_fctrl (
    .clk(clk), .rst_n(rst_n), .go(go_f), .hold(trigger),
    .busy(fc_busy), .step(fc_step), .last(fc_last)
  );

  wm_pay_ctrl #(.OP_KEY(OP_KEY)) u_pctrl (
    .clk(clk), .rst_n(rst_n), .go(go_p),
    .busy(pc_busy), .step(pc_step), .last(pc_last),
    .keep(pc_keep), .load_const(pc_lc), .store_we(pc_we), .sig_add(pc_sig)
  );

  // Shared step decode comes from whichever controller runs; mode-dependent
  // controls are steered by the latched mode (payload controller busy).
  assign fsc        = sched_at(fc_step);
  assign step       = pc_busy ? pc_step : fc_step;
  assign step_en    = fc_busy || pc_busy;
  assign finish     = pc_busy ? pc_last : fc_last;
  assign keep       = pc_busy ? pc_keep : 1'b1;
  assign load_const = pc_busy ? pc_lc   : 1'b0;
  assign store_we   = pc_busy ? pc_we   : (fsc.kind == K_STORE);
  assign sig_add    = pc_busy ? pc_sig  : 1'b0;

  wm_datapath #(.DW(DW), .LOAD_CONST(LOAD_CONST)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .a_in(input_a), .b_in(input_b),
    .step_en(step_en), .step(step), .keep(keep), .load_const(load_const),
    .store_we(store_we), .sig_add(sig_add), .finish(finish), .sel_sig(pc_busy),
    .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= finish;
  end

  // R4: the two controllers never own the datapath together
  p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fc_busy && pc_busy));

  // R1: an accepted job closes the input side on the next cycle
  p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R2: the strobe lasts one cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: the strobe follows the last step
  p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && in_ready));

endmodule

// File: tb/tb_wm_kernel.sv
`timescale 1ns/1ps
module tb_wm_kernel;

  localparam logic [7:0]  KEY_A = 8'h23;
  localparam logic [7:0]  KEY_B = 8'hDC;
  localparam logic [31:0] KC    = 32'h5A5A_C3C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, trigger = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic rdy0, rdy1, done0, done1;
  logic [31:0] res0, res1;
  int checks = 0, fails = 0, cycles = 0;

  always #4 clk = ~clk;

  wm_kernel #(.DW(32), .OP_KEY(KEY_A), .LOAD_CONST(KC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_ready(rdy0), .trigger(trigger),
    .input_a(a), .input_b(b), .result(res0), .done(done0));

  wm_kernel #(.DW(32), .OP_KEY(KEY_B), .LOAD_CONST(KC)) dut_alt (
    .clk(clk), .rst_n(rst_n), .start(start), .in_ready(rdy1), .trigger(trigger),
    .input_a(a), .input_b(b), .result(res1), .done(done1));

  function automatic logic [31:0] f_model(input logic [31:0] x, input logic [31:0] y);
    logic [31:0] s;
    s = x + y;
    return (((x ^ y) - s) & s) + s;
  endfunction

  function automatic logic [31:0] p_model(input logic [31:0] x, input logic [31:0] y,
                                          input logic [7:0] k);
    logic [31:0] r0, r1, r2, r3, sig;
    r0  = k[0] ? x + y : x;
    r1  = k[1] ? x ^ y : y;
    sig = r0;
    r2  = k[3] ? r1 - r0 : r0;
    r3  = KC;
    r2  = k[5] ? r2 & r3 : r2;
    r0  = r2 + r3;
    return sig + r0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one job; mid_trig/mid_start disturb it at the third negedge.
  task automatic run_job(input logic [31:0] x, input logic [31:0] y, input bit trig,
                         input bit mid_trig, input bit mid_start,
                         input logic [31:0] e0, input logic [31:0] e1, input string req);
    int cyc;
    @(negedge clk);
    a = x; b = y; trigger = trig; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    chk(!rdy0, "R1 ready low after accept", 32'(rdy0), 32'd0);
    while (!done0 && cyc < 20) begin
      @(negedge clk); cyc++;
      if (cyc == 3) begin
        if (mid_trig) trigger = ~trig;
        if (mid_start) begin start = 1'b1; a = ~x; b = x ^ 32'h1234_0000; end
      end
      if (cyc == 4) start = 1'b0;
    end
    chk(cyc == 9, "R2 done latency", 32'(cyc), 32'd9);
    chk(rdy0 && rdy1 && done1, "R1 ready back with done", {29'd0, rdy0, rdy1, done1}, 32'd7);
    chk(res0 == e0, req, res0, e0);
    chk(res1 == e1, req, res1, e1);
    trigger = 1'b0;
    @(negedge clk);
    chk(!done0, "R2 done one cycle", 32'(done0), 32'd0);
    chk(res0 == e0, "R2 result held", res0, e0);
  endtask

  task automatic t_reset();
    chk(rdy0 == 1'b1, "R1 reset ready", 32'(rdy0), 32'd1);
    chk(done0 == 1'b0, "R1 reset done", 32'(done0), 32'd0);
    chk(res0 == 32'd0, "R1 reset result", res0, 32'd0);
  endtask

  task automatic t_functional();
    logic [31:0] xs [5] = '{32'h0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0000, 32'hA5A5_A5A5};
    logic [31:0] ys [5] = '{32'h0, 32'h1,         32'h9ABC_DEF0, 32'h8000_0000, 32'h5A5A_5A5A};
    for (int i = 0; i < 5; i++)
      run_job(xs[i], ys[i], 1'b0, 1'b0, 1'b0, f_model(xs[i], ys[i]), f_model(xs[i], ys[i]),
              "R3 functional result");
  endtask

  task automatic t_payload();
    logic [31:0] xs [3] = '{32'h1234_5678, 32'hFFFF_FFFF, 32'h0F0F_00FF};
    logic [31:0] ys [3] = '{32'h9ABC_DEF0, 32'h0000_0001, 32'h3333_CCCC};
    for (int i = 0; i < 3; i++)
      run_job(xs[i], ys[i], 1'b1, 1'b0, 1'b0, p_model(xs[i], ys[i], KEY_A),
              p_model(xs[i], ys[i], KEY_B), "R5 R6 R7 R8 signature");
  endtask

  task automatic t_mode_latch();
    run_job(32'hDEAD_BEEF, 32'h0BAD_F00D, 1'b0, 1'b1, 1'b0,
            f_model(32'hDEAD_BEEF, 32'h0BAD_F00D), f_model(32'hDEAD_BEEF, 32'h0BAD_F00D),
            "R4 trigger rise mid job ignored");
    run_job(32'h1357_9BDF, 32'h2468_ACE0, 1'b1, 1'b1, 1'b0,
            p_model(32'h1357_9BDF, 32'h2468_ACE0, KEY_A),
            p_model(32'h1357_9BDF, 32'h2468_ACE0, KEY_B), "R4 trigger fall mid job ignored");
  endtask

  task automatic t_busy_start();
    run_job(32'h7777_0001, 32'h0000_9999, 1'b0, 1'b0, 1'b1,
            f_model(32'h7777_0001, 32'h0000_9999), f_model(32'h7777_0001, 32'h0000_9999),
            "R1 start while busy ignored");
  endtask

  task automatic t_trigger_idle();
    bit seen = 1'b0;
    @(negedge clk);
    trigger = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done0 || !rdy0) seen = 1'b1;
    end
    trigger = 1'b0;
    chk(!seen, "R4 trigger alone starts nothing", 32'(seen), 32'd0);
  endtask

  task automatic t_after_payload();
    run_job(32'hCAFE_0000, 32'h0000_BABE, 1'b1, 1'b0, 1'b0,
            p_model(32'hCAFE_0000, 32'h0000_BABE, KEY_A),
            p_model(32'hCAFE_0000, 32'h0000_BABE, KEY_B), "R8 signature before functional");
    run_job(32'h0101_0101, 32'hF0F0_F0F0, 1'b0, 1'b0, 1'b0,
            f_model(32'h0101_0101, 32'hF0F0_F0F0), f_model(32'h0101_0101, 32'hF0F0_F0F0),
            "R9 functional after signature");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    #20;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_functional();
    t_payload();
    t_mode_latch();
    t_busy_start();
    t_trigger_idle();
    t_after_payload();
    finish_run();
  end

endmodule